// File: doc/BRIEF.md
# Memory range signature compressor

This block reduces a contiguous span of 16-bit memory words to a single 16-bit signature. The span is given by a low and a high address. A one-cycle start pulse launches an operation. The block then drives a synchronous read port and shifts every returned word into a multiple-input signature register (MISR). The span is swept twice: first from the low address up to the high address, then from the high address back down to the low address. A fixed constant is folded in before the first sweep. After the second sweep the register is folded with its own value, and the result is captured in a held output register.

The read port follows stream rules. `rd_en` is the request valid and `rd_rdy` is the memory's ready. A request is accepted in any cycle where both are high. While `rd_rdy` is low, the block keeps `rd_en` high and holds `rd_addr` unchanged, and the sweep does not advance. Read data for an accepted request arrives on `rd_data` exactly one cycle after acceptance. The return path has no back-pressure: the block always consumes the word in that cycle. Control and status pins (`start`, `busy`, `done`) are plain level or pulse signals.

Top module: `range_sig_comp`

## Requirements
- R1: One compression step maps the signature S and a data word D to {S[14:0], S[15]^S[4]^S[2]^S[1]} ^ D.
- R2: An accepted start loads the signature with 0xFFFF. The next step folds the constant 0xFFFF, which leaves 0x0001, and this happens before any memory word is folded.
- R3: The block issues reads for every address from `lo_addr` up to `hi_addr` in rising order, then for every address from `hi_addr` down to `lo_addr` in falling order. That is 2*(hi-lo+1) accepted reads in total, and `lo_addr` <= `hi_addr` is assumed.
- R4: The word on `rd_data` one cycle after each accepted read is folded exactly once, in issue order. No word is lost or repeated where the rising sweep turns into the falling sweep.
- R5: While `rd_en` is high and `rd_rdy` is low, `rd_en` stays high and `rd_addr` keeps its value in the next cycle. `rd_en` is low whenever the block is idle.
- R6: After both sweeps the signature is folded with itself as data. That value appears on `sig_out` together with a `done` pulse that lasts exactly one cycle.
- R7: A range with `lo_addr` equal to `hi_addr` reads that one address twice and then completes normally.
- R8: `busy` rises in the cycle after an accepted start and falls in the cycle `done` is high. A start pulse while `busy` is high changes neither the range nor the result.
- R9: `sig_out` changes only in a cycle where `done` is high, and otherwise holds its value.
- R10: A synchronous active-high `rst` returns the block to idle with `busy`, `done` and `rd_en` low, and leaves `sig_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, accepted only while idle |
| lo_addr | input | AW | First address of the range |
| hi_addr | input | AW | Last address of the range |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| sig_out | output | 16 | Last completed signature |
| rd_en | output | 1 | Read request valid |
| rd_rdy | input | 1 | Read request ready from memory |
| rd_addr | output | AW | Read address |
| rd_data | input | 16 | Read data, one cycle after acceptance |

## Verification
The hardest case to reach from the ports is the turnaround from the rising sweep to the falling sweep while the read port is stalling. At that point the high address must be accepted once per sweep, and a word is still in flight during the transfer. To reach it, a gated-ready pattern from a bench LFSR is replayed over small ranges so that stalls land on both sides of the turnaround. The single-word range is also run, because there both sweeps collapse onto one address. Every accepted address is logged and compared with the expected up-then-down order, and every signature is compared with a bench model of the full fold sequence.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int unsigned SIG_W = 16;
  localparam logic [SIG_W-1:0] TAP_MASK  = 16'h8016; // bits 15,4,2,1
  localparam logic [SIG_W-1:0] INIT_WORD = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEED, ST_RUN, ST_DRAIN, ST_SELF
  } seq_st_e;

  typedef enum logic [2:0] {
    OP_HOLD, OP_INIT, OP_SEED, OP_DATA, OP_SELF
  } misr_op_e;
endpackage

// File: rtl/rsc_misr.sv
module rsc_misr
  import rsc_pkg::*;
#(
  parameter int unsigned W = SIG_W
) (
  input  logic         clk,
  input  misr_op_e     op,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next
);
  logic [W-1:0] q_r;
  logic [W-1:0] fold_in;
  logic [W-1:0] stepped;
  logic         fb;

  // select the word to fold: constant, memory word or own value
  always_comb begin
    case (op)
      OP_SEED: fold_in = INIT_WORD;
      OP_SELF: fold_in = q_r;
      default: fold_in = din;
    endcase
  end

  assign fb = ^(q_r & TAP_MASK);

  // one stage per bit: shift left, feedback into bit 0, xor data
  for (genvar i = 0; i < int'(W); i++) begin : g_stage
    if (i == 0) begin : g_head
      assign stepped[i] = fb ^ fold_in[i];
    end else begin : g_body
      assign stepped[i] = q_r[i-1] ^ fold_in[i];
    end
  end

  always_comb begin
    case (op)
      OP_HOLD: q_next = q_r;
      OP_INIT: q_next = INIT_WORD;
      default: q_next = stepped;
    endcase
  end

  always_ff @(posedge clk) q_r <= q_next;

  assign q = q_r;
endmodule

// File: rtl/rsc_walker.sv
module rsc_walker #(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic [AW-1:0] addr,
  output logic          last
);
  logic [AW-1:0] lo_q, hi_q, addr_q;
  logic          down_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      hi_q   <= '0;
      addr_q <= '0;
      down_q <= 1'b0;
    end else if (load) begin
      lo_q   <= lo;
      hi_q   <= hi;
      addr_q <= lo;
      down_q <= 1'b0;
    end else if (adv) begin
      if (!down_q) begin
        // top reached: turn around, high address is issued again
        if (addr_q == hi_q) down_q <= 1'b1;
        else                addr_q <= addr_q + 1'b1;
      end else if (addr_q != lo_q) begin
        addr_q <= addr_q - 1'b1;
      end
    end
  end

  assign addr = addr_q;
  assign last = down_q && (addr_q == lo_q);
endmodule

// File: rtl/range_sig_comp.sv
module range_sig_comp
  import rsc_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] lo_addr,
  input  logic [AW-1:0] hi_addr,
  output logic          busy,
  output logic          done,
  output logic [15:0]   sig_out,
  output logic          rd_en,
  input  logic          rd_rdy,
  output logic [AW-1:0] rd_addr,
  input  logic [15:0]   rd_data
);
  seq_st_e        st_q, st_d;
  misr_op_e       op;
  logic           accept;
  logic           pend_q;
  logic           walk_last;
  logic           in_seed;
  logic [SIG_W-1:0] misr_q, misr_d, sig_q;
  logic           done_q;

  assign rd_en   = (st_q == ST_RUN);
  assign accept  = rd_en && rd_rdy;
  assign in_seed = (st_q == ST_SEED);

  rsc_walker #(.AW(AW)) u_walk (
    .clk  (clk),
    .rst  (rst),
    .load (st_q == ST_IDLE && start),
    .adv  (accept),
    .lo   (lo_addr),
    .hi   (hi_addr),
    .addr (rd_addr),
    .last (walk_last)
  );

  rsc_misr #(.W(SIG_W)) u_misr (
    .clk    (clk),
    .op     (op),
    .din    (rd_data),
    .q      (misr_q),
    .q_next (misr_d)
  );

  always_comb begin
    st_d = st_q;
    op   = OP_HOLD;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d = ST_SEED;
        op   = OP_INIT;
      end
      ST_SEED: begin
        op   = OP_SEED;
        st_d = ST_RUN;
      end
      ST_RUN: begin
        if (pend_q) op = OP_DATA;
        if (accept && walk_last) st_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (pend_q) op = OP_DATA;
        st_d = ST_SELF;
      end
      ST_SELF: begin
        op   = OP_SELF;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= accept;
      done_q <= (st_q == ST_SELF);
    end
  end

  // result register: no reset, written only on completion
  always_ff @(posedge clk) begin
    if (!rst && st_q == ST_SELF) sig_q <= misr_d;
  end

  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
  assign sig_out = sig_q;
endmodule

// File: rtl/range_sig_comp_chk.sv
module range_sig_comp_chk #(
  parameter int unsigned AW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [15:0]   sig_out,
  input logic          rd_en,
  input logic          rd_rdy,
  input logic [AW-1:0] rd_addr,
  input logic          seed_ph,
  input logic [15:0]   misr
);
  AST_SEED_ONE: assert property (@(posedge clk) disable iff (rst)
    seed_ph |=> misr == 16'h0001); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_en && !rd_rdy |=> rd_en && $stable(rd_addr)); // R5
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rd_en); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy)); // R8
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start)); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(sig_out)); // R9
endmodule

bind range_sig_comp range_sig_comp_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .sig_out (sig_out),
  .rd_en   (rd_en),
  .rd_rdy  (rd_rdy),
  .rd_addr (rd_addr),
  .seed_ph (in_seed),
  .misr    (misr_q)
);

// File: tb/tb_range_sig_comp.sv
module tb_range_sig_comp;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] lo_addr = '0, hi_addr = '0;
  logic          busy, done, rd_en, rd_rdy;
  logic [15:0]   sig_out, rd_data;
  logic [AW-1:0] rd_addr;

  int total = 0;
  int bad = 0;
  int stall_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] mem [DEPTH];

  int log_n = 0;
  int log_addr [2*DEPTH];
  int hold_err = 0;
  logic prev_stall = 1'b0;
  logic [AW-1:0] prev_addr = '0;

  always #5 clk = ~clk;

  range_sig_comp #(.AW(AW)) dut (
    .clk(clk), .rst(rst), .start(start), .lo_addr(lo_addr), .hi_addr(hi_addr),
    .busy(busy), .done(done), .sig_out(sig_out), .rd_en(rd_en),
    .rd_rdy(rd_rdy), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // memory model: one-cycle read latency
  always @(posedge clk) if (rd_en && rd_rdy) rd_data <= mem[rd_addr];

  // request log and hold check
  always @(posedge clk) begin
    if (!rst) begin
      if (prev_stall && !(rd_en && rd_addr == prev_addr)) hold_err++;
      if (rd_en && rd_rdy && log_n < 2*DEPTH) begin
        log_addr[log_n] = int'(rd_addr);
        log_n++;
      end
      prev_stall = rd_en && !rd_rdy;
      prev_addr  = rd_addr;
    end else prev_stall = 1'b0;
  end

  // ready pattern driven away from the active edge
  always @(negedge clk) begin
    lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rd_rdy <= (stall_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
  end

  function automatic logic [15:0] step(input logic [15:0] s, input logic [15:0] d);
    return {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]} ^ d;
  endfunction

  function automatic logic [15:0] model(input int lo, input int hi);
    logic [15:0] m = 16'hFFFF;
    m = step(m, 16'hFFFF);
    for (int a = lo; a <= hi; a++) m = step(m, mem[a]);
    for (int a = hi; a >= lo; a--) m = step(m, mem[a]);
    return step(m, m);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic launch(input int lo, input int hi);
    @(negedge clk);
    lo_addr = AW'(lo); hi_addr = AW'(hi); start = 1'b1;
    log_n = 0; hold_err = 0;
    @(negedge clk);
    start = 1'b0;
  endtask

  // waits for done; returns cycles waited, -1 on timeout
  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (cyc > 5000) begin cyc = -1; return; end
    end
  endtask

  task automatic check_order(input int lo, input int hi, input string req);
    int ok = (log_n == 2*(hi-lo+1));
    int k = 0;
    for (int a = lo; a <= hi; a++) begin if (ok && log_addr[k] != a) ok = 0; k++; end
    for (int a = hi; a >= lo; a--) begin if (ok && log_addr[k] != a) ok = 0; k++; end
    check(ok != 0, req, log_n, 2*(hi-lo+1));
  endtask

  task automatic run_checked(input int lo, input int hi, input string tag);
    int cyc;
    launch(lo, hi);
    check(busy == 1'b1, {tag, " R8 busy after start"}, busy, 1);
    wait_done(cyc);
    check(cyc >= 0, {tag, " R6 completes"}, cyc, 0);
    check(sig_out == model(lo, hi), {tag, " R1 R2 R4 signature"}, sig_out, model(lo, hi));
    check(busy == 1'b0, {tag, " R8 busy low at done"}, busy, 0);
    check_order(lo, hi, {tag, " R3 address order"});
    check(hold_err == 0, {tag, " R5 request held under stall"}, hold_err, 0);
    @(negedge clk);
    check(done == 1'b0, {tag, " R6 done one cycle"}, done, 0);
  endtask

  task automatic t_reset();
    check(busy == 0 && done == 0 && rd_en == 0, "R10 reset state", {busy, done, rd_en}, 0);
  endtask

  task automatic t_basic();
    stall_mode = 0;
    run_checked(3, 9, "basic");
    run_checked(0, DEPTH-1, "full");
  endtask

  task automatic t_single();
    stall_mode = 0;
    run_checked(5, 5, "R7 single");
    stall_mode = 1;
    run_checked(200, 200, "R7 single stall");
  endtask

  task automatic t_stall();
    stall_mode = 1;
    for (int i = 0; i < 6; i++) run_checked(10 + i, 12 + 2*i, "R4 R5 stall");
    stall_mode = 0;
  endtask

  task automatic t_busy_ignore();
    int cyc;
    launch(20, 30);
    for (int i = 0; i < 4; i++) @(negedge clk);
    lo_addr = 8'd0; hi_addr = 8'd200; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    check(sig_out == model(20, 30), "R8 start while busy ignored", sig_out, model(20, 30));
    check_order(20, 30, "R8 range unchanged by late start");
    @(negedge clk);
    check(busy == 1'b0, "R8 no relaunch", busy, 0);
  endtask

  task automatic t_hold_and_reset();
    logic [15:0] keep;
    run_checked(40, 44, "R9 prep");
    keep = sig_out;
    for (int i = 0; i < 8; i++) @(negedge clk);
    check(sig_out == keep, "R9 result holds while idle", sig_out, keep);
    launch(50, 90);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (sig_out != keep) break;
    end
    check(sig_out == keep, "R9 result holds during run", sig_out, keep);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check(busy == 0 && rd_en == 0 && done == 0, "R10 reset mid run idles", {busy, rd_en, done}, 0);
    check(sig_out == keep, "R10 reset keeps result", sig_out, keep);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 0, "R10 stays idle after reset", busy, 0);
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) mem[a] = 16'((a * 40503) ^ (a << 9) ^ 16'h5A3C);
    rd_rdy = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_basic();
    t_single();
    t_stall();
    t_busy_ignore();
    t_hold_and_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule